// File: doc/BRIEF.md
# Parallel Configuration Stream Loader

This block moves a configuration image, one byte at a time, from a local byte source onto an 8-bit parallel slave configuration port of a programmable logic device. The source offers bytes with a valid/ready handshake and marks the final byte with a last flag. The loader owns the active-low program, chip-select and read/write strobes and the data bus with its output enable. It watches the device's active-low init and busy lines.

One of two modes is chosen by the mode input sampled with the start pulse. A full load first clears the device with a program pulse. It then waits for init to fall and rise again before it opens the port. A partial load leaves the device's existing contents alone: it never pulses program and never waits on init, because clearing the device would also wipe the logic that runs the loader. In both modes the loader opens a write transaction and presents a few padding bytes followed by the eight-byte synchronisation word. It then streams the payload and closes the port after the last byte.

Top module: `parcfg_loader`

## Requirements
- R1: Out of reset, progN, csN and rdwrN are high, cfgDataOe, srcReady, done and error are low.
- R2: In full mode (partialMode=0 at start), progN is low for exactly PROG_CYCLES consecutive clocks, beginning in the clock after the start edge.
- R3: In full mode, rdwrN stays high until the device has driven initN low and then high again after program was released.
- R4: If either init phase does not complete within INIT_TIMEOUT clocks, error goes high and stays high, no transfer is opened, and the block returns to idle; the next start clears error.
- R5: In partial mode (partialMode=1 at start), progN never goes low and initN is not waited on.
- R6: The byte sequence written to the device is DUMMY_BYTES bytes of 0xFF, then FF FF FF FF AA 99 55 66 in that order, then every payload byte in source order.
- R7: A byte is written on each rising edge where csN is low and busy is low; while busy is high, cfgData and csN hold their values and srcReady is low.
- R8: rdwrN is low for the whole transfer and whenever csN is low; csN is low only while a byte is presented, and cfgDataOe is high exactly when csN is low.
- R9: After the byte marked last is written, csN and rdwrN return high, and done is high for exactly one clock while both strobes are high.
- R10: A start pulse that arrives while a load is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a load when idle |
| partialMode | input | 1 | 1 selects partial load, 0 selects full load; sampled with start |
| srcData | input | 8 | Byte from the image source |
| srcValid | input | 1 | srcData holds a byte |
| srcLast | input | 1 | The offered byte is the final one |
| srcReady | output | 1 | Loader takes the offered byte on this edge |
| progN | output | 1 | Active-low device clear |
| csN | output | 1 | Active-low chip select |
| rdwrN | output | 1 | Low selects write direction |
| cfgData | output | 8 | Configuration data bus |
| cfgDataOe | output | 1 | Bus output enable |
| initN | input | 1 | Active-low device init status |
| busy | input | 1 | Device cannot take a byte this cycle |
| done | output | 1 | One-clock pulse when a load completes |
| error | output | 1 | Init timeout, held until the next start |

## Verification
A wrong sequencer state shows at the strobes within a clock. A stray program pulse, or a transfer opened before init completes, appears on progN or rdwrN in the very cycle it happens. A wrong preamble index or a lost payload byte changes the first written byte after the fault, which the bench catches on that edge by comparing each captured byte with an arithmetic expectation. A broken busy hold shows as a changed bus value or a released chip select in the clock right after a stalled edge.

// File: rtl/parcfg_pkg.sv
`timescale 1ns/1ps
package parcfg_pkg;

  localparam int SYNC_LEN = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROG,
    ST_INITLO,
    ST_INITHI,
    ST_PRE,
    ST_PAY,
    ST_CLOSE
  } cfgState_t;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic clrXfer;
    logic inPre;
    logic inPay;
  } dpStrobe_t;

  // padding bytes, then the sync word
  function automatic logic [7:0] preambleByte(input int idx, input int dummies);
    logic [7:0] b;
    if (idx < dummies) begin
      b = 8'hFF;
    end else begin
      case (idx - dummies)
        0, 1, 2, 3: b = 8'hFF;
        4:          b = 8'hAA;
        5:          b = 8'h99;
        6:          b = 8'h55;
        7:          b = 8'h66;
        default:    b = 8'h00;
      endcase
    end
    return b;
  endfunction

endpackage

// File: rtl/parcfg_ctrl.sv
`timescale 1ns/1ps
module parcfg_ctrl
  import parcfg_pkg::*;
#(
  parameter int PROG_CYCLES  = 4,
  parameter int INIT_TIMEOUT = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       partialMode,
  input  logic       initN,
  input  logic       preEnd,
  input  logic       payEnd,
  output dpStrobe_t  strb,
  output logic       progN,
  output logic       rdwrN,
  output logic       done,
  output logic       error
);

  localparam int CNT_MAX = (PROG_CYCLES > INIT_TIMEOUT) ? PROG_CYCLES : INIT_TIMEOUT;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] PROG_LAST = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] WAIT_LAST = CNT_W'(INIT_TIMEOUT - 1);

  cfgState_t        state;
  logic [CNT_W-1:0] cnt;
  logic             errQ;
  logic             modeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      errQ  <= 1'b0;
      modeQ <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            errQ  <= 1'b0;
            modeQ <= partialMode;
            cnt   <= '0;
            state <= partialMode ? ST_PRE : ST_PROG;
          end
        end
        ST_PROG: begin
          if (cnt == PROG_LAST) begin
            cnt   <= '0;
            state <= ST_INITLO;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_INITLO: begin
          if (!initN) begin
            cnt   <= '0;
            state <= ST_INITHI;
          end else if (cnt == WAIT_LAST) begin
            errQ  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_INITHI: begin
          if (initN) begin
            cnt   <= '0;
            state <= ST_PRE;
          end else if (cnt == WAIT_LAST) begin
            errQ  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PRE:   if (preEnd) state <= ST_PAY;
        ST_PAY:   if (payEnd) state <= ST_CLOSE;
        ST_CLOSE: state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.inPre   = (state == ST_PRE);
    strb.inPay   = (state == ST_PAY);
    strb.clrXfer = !(strb.inPre || strb.inPay);
  end

  assign progN = (state != ST_PROG);
  assign rdwrN = !(state == ST_PRE || state == ST_PAY);
  assign done  = (state == ST_CLOSE);
  assign error = errQ;

  // R5
  partial_no_prog_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ && state != ST_IDLE) |-> progN);

  // R2
  prog_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(progN) |-> (!$past(progN, 1) && !$past(progN, 2) &&
                      !$past(progN, 3) && !$past(progN, 4)));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R4
  error_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errQ) |-> ($past(state) == ST_INITLO || $past(state) == ST_INITHI));

endmodule

// File: rtl/parcfg_dpath.sv
`timescale 1ns/1ps
module parcfg_dpath
  import parcfg_pkg::*;
#(
  parameter int DUMMY_BYTES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobe_t  strb,
  input  logic       busy,
  input  logic [7:0] srcData,
  input  logic       srcValid,
  input  logic       srcLast,
  output logic       srcReady,
  output logic [7:0] cfgData,
  output logic       cfgDataOe,
  output logic       preEnd,
  output logic       payEnd
);

  localparam int PRE_LEN = DUMMY_BYTES + SYNC_LEN;
  localparam int IDX_W   = $clog2(PRE_LEN + 1);
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(PRE_LEN);

  logic [7:0]       dataQ;
  logic             haveQ;
  logic             lastQ;
  logic [IDX_W-1:0] idxQ;
  logic             consume;

  assign consume  = haveQ && !busy;
  assign srcReady = strb.inPay && !busy && !lastQ;
  assign preEnd   = strb.inPre && consume && (idxQ == IDX_END);
  assign payEnd   = strb.inPay && consume && lastQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataQ <= '0;
      haveQ <= 1'b0;
      lastQ <= 1'b0;
      idxQ  <= '0;
    end else if (strb.clrXfer) begin
      haveQ <= 1'b0;
      lastQ <= 1'b0;
      idxQ  <= '0;
    end else if (!busy) begin
      if (strb.inPre) begin
        if (idxQ < IDX_END) begin
          dataQ <= preambleByte(int'(idxQ), DUMMY_BYTES);
          haveQ <= 1'b1;
          idxQ  <= idxQ + 1'b1;
        end else begin
          haveQ <= 1'b0;
        end
      end else if (strb.inPay) begin
        if (srcValid && !lastQ) begin
          dataQ <= srcData;
          haveQ <= 1'b1;
          lastQ <= srcLast;
        end else begin
          haveQ <= 1'b0;
        end
      end
    end
  end

  assign cfgData   = dataQ;
  assign cfgDataOe = haveQ;

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cfgDataOe) |=> (cfgDataOe && $stable(cfgData)));

endmodule

// File: rtl/parcfg_loader.sv
`timescale 1ns/1ps
module parcfg_loader
  import parcfg_pkg::*;
#(
  parameter int DUMMY_BYTES  = 2,
  parameter int PROG_CYCLES  = 4,
  parameter int INIT_TIMEOUT = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       partialMode,
  input  logic [7:0] srcData,
  input  logic       srcValid,
  input  logic       srcLast,
  output logic       srcReady,
  output logic       progN,
  output logic       csN,
  output logic       rdwrN,
  output logic [7:0] cfgData,
  output logic       cfgDataOe,
  input  logic       initN,
  input  logic       busy,
  output logic       done,
  output logic       error
);

  dpStrobe_t strb;
  logic      preEnd;
  logic      payEnd;
  logic      oe;

  parcfg_ctrl #(
    .PROG_CYCLES (PROG_CYCLES),
    .INIT_TIMEOUT(INIT_TIMEOUT)
  ) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .partialMode(partialMode),
    .initN      (initN),
    .preEnd     (preEnd),
    .payEnd     (payEnd),
    .strb       (strb),
    .progN      (progN),
    .rdwrN      (rdwrN),
    .done       (done),
    .error      (error)
  );

  parcfg_dpath #(
    .DUMMY_BYTES(DUMMY_BYTES)
  ) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .busy     (busy),
    .srcData  (srcData),
    .srcValid (srcValid),
    .srcLast  (srcLast),
    .srcReady (srcReady),
    .cfgData  (cfgData),
    .cfgDataOe(oe),
    .preEnd   (preEnd),
    .payEnd   (payEnd)
  );

  assign cfgDataOe = oe;
  assign csN       = !oe;

  // R8
  cs_needs_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> !rdwrN);

endmodule

// File: tb/sim_parcfg_loader.sv
`timescale 1ns/1ps
module sim_parcfg_loader;

  localparam int DUMMY  = 2;
  localparam int PROGC  = 4;
  localparam int TMO    = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic       partialMode = 1'b0;
  logic [7:0] srcData = '0;
  logic       srcValid = 1'b0;
  logic       srcLast = 1'b0;
  logic       srcReady;
  logic       progN, csN, rdwrN, cfgDataOe, done, error;
  logic [7:0] cfgData;
  logic       initN = 1'b1;
  logic       busy = 1'b0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  parcfg_loader #(
    .DUMMY_BYTES (DUMMY),
    .PROG_CYCLES (PROGC),
    .INIT_TIMEOUT(TMO)
  ) u0 (
    .clk(clk), .rstN(rstN), .start(start), .partialMode(partialMode),
    .srcData(srcData), .srcValid(srcValid), .srcLast(srcLast), .srcReady(srcReady),
    .progN(progN), .csN(csN), .rdwrN(rdwrN), .cfgData(cfgData), .cfgDataOe(cfgDataOe),
    .initN(initN), .busy(busy), .done(done), .error(error)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] payByte(input int seed, input int k);
    return 8'((seed * 37 + k * 29 + 5) & 255);
  endfunction

  function automatic logic [7:0] syncByte(input int i);
    case (i)
      4: return 8'hAA;
      5: return 8'h99;
      6: return 8'h55;
      7: return 8'h66;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic bit busyAt(input int pat, input int cyc);
    case (pat)
      1: return (cyc % 3) == 1;
      2: return (cyc % 5) >= 3;
      default: return 1'b0;
    endcase
  endfunction

  task automatic runXfer(input bit partial, input int nBytes, input int busyPat,
                         input int gapPat, input int seed, input bit poke);
    logic [7:0] expB [0:63];
    int total, capN, srcIdx, progLow, rose, doneCnt, doneCyc, badByte, firstBad;
    bit prevProgLow, prevHold;
    logic [7:0] prevData;
    total = DUMMY + 8 + nBytes;
    for (int i = 0; i < DUMMY; i++) expB[i] = 8'hFF;
    for (int i = 0; i < 8; i++) expB[DUMMY + i] = syncByte(i);
    for (int k = 0; k < nBytes; k++) expB[DUMMY + 8 + k] = payByte(seed, k);
    capN = 0; srcIdx = 0; progLow = 0; rose = -1; doneCnt = 0; doneCyc = -1;
    badByte = 0; firstBad = -1; prevProgLow = 0; prevHold = 0; prevData = '0;
    for (int cyc = 0; cyc < 600; cyc++) begin
      @(negedge clk);
      start       = (cyc == 0) || (poke && cyc == 4);
      partialMode = (cyc == 0) ? partial : !partial;
      busy        = busyAt(busyPat, cyc);
      srcValid    = (srcIdx < nBytes) && (gapPat == 0 || (cyc % 2) == 0);
      srcData     = payByte(seed, srcIdx);
      srcLast     = (srcIdx == nBytes - 1);
      initN       = (rose < 0) || !(cyc >= rose + 2 && cyc < rose + 6);
      #1;
      if (cyc == 1) chk(error == 1'b0, "R4 error cleared by start", error, 0);
      if (!progN) progLow++;
      if (prevProgLow && progN && rose < 0) rose = cyc;
      prevProgLow = !progN;
      if (partial && !progN)
        chk(1'b0, poke ? "R10 program pulsed by ignored start" : "R5 program in partial mode", 0, 1);
      if (!partial && !rdwrN && !(rose >= 0 && cyc >= rose + 6))
        chk(1'b0, "R3 write before init cycle", cyc, rose + 6);
      if (cfgDataOe == csN) chk(1'b0, "R8 oe vs csN", cfgDataOe, !csN);
      if (!csN && rdwrN) chk(1'b0, "R8 csN low with rdwrN high", rdwrN, 0);
      if (busy && srcReady) chk(1'b0, "R7 ready while busy", srcReady, 0);
      if (prevHold && (csN || cfgData != prevData))
        chk(1'b0, "R7 bus hold under busy", cfgData, prevData);
      prevHold = busy && !csN;
      prevData = cfgData;
      if (!csN && !busy) begin
        if (capN < total && cfgData != expB[capN]) begin
          badByte++;
          if (firstBad < 0) firstBad = capN;
          $display("FAIL R6 byte %0d actual=%0h expected=%0h", capN, cfgData, expB[capN]);
        end
        capN++;
      end
      if (srcValid && srcReady) srcIdx++;
      if (done) begin
        doneCnt++;
        if (doneCyc < 0) doneCyc = cyc;
        chk(csN && rdwrN, "R9 strobes high at done", {csN, rdwrN}, 3);
        chk(capN == total, "R9 done after last byte", capN, total);
      end
      if (doneCyc >= 0 && cyc == doneCyc + 3) break;
    end
    start = 1'b0;
    srcValid = 1'b0;
    busy = 1'b0;
    chk(capN == total, "R6 byte count", capN, total);
    checks++;
    if (badByte != 0) errors++;
    chk(doneCnt == 1, "R9 single done pulse", doneCnt, 1);
    chk(srcIdx == nBytes, "R7 all source bytes taken", srcIdx, nBytes);
    chk(error == 1'b0, "R4 no error on good load", error, 0);
    if (!partial) chk(progLow == PROGC, "R2 program width", progLow, PROGC);
    else          chk(progLow == 0, "R5 no program pulse", progLow, 0);
  endtask

  task automatic runTimeout();
    bit opened;
    opened = 0;
    for (int cyc = 0; cyc < 40; cyc++) begin
      @(negedge clk);
      start = (cyc == 0);
      partialMode = 1'b0;
      initN = 1'b1;
      #1;
      if (!rdwrN || !csN) opened = 1;
      if (cyc == PROGC + TMO) chk(error == 1'b0, "R4 error not early", error, 0);
      if (cyc == PROGC + TMO + 1) chk(error == 1'b1, "R4 error at timeout", error, 1);
    end
    start = 1'b0;
    chk(!opened, "R4 no transfer after timeout", opened, 0);
    chk(error == 1'b1, "R4 error held", error, 1);
    chk(progN == 1'b1, "R4 back to idle", progN, 1);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    #1;
    chk(progN && csN && rdwrN, "R1 strobes high in reset", {progN, csN, rdwrN}, 7);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    chk(progN && csN && rdwrN, "R1 strobes high after reset", {progN, csN, rdwrN}, 7);
    chk(!cfgDataOe && !srcReady, "R1 bus and ready idle", {cfgDataOe, srcReady}, 0);
    chk(!done && !error, "R1 done and error low", {done, error}, 0);
    runTimeout();
    for (int m = 0; m < 2; m++)
      for (int n = 1; n <= 5; n++)
        for (int b = 0; b < 3; b++)
          for (int g = 0; g < 2; g++)
            runXfer(bit'(m), n, b, g, n * 7 + b * 3 + g + m, 1'b0);
    runXfer(1'b1, 4, 1, 0, 11, 1'b1);
    runXfer(1'b0, 3, 0, 0, 5, 1'b1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule